// File: doc/BRIEF.md
# Priority Cartridge Address Decoder

This block is the memory map of a console cartridge controller. Each request carries a 24-bit bus address (8-bit bank, 16-bit offset), a write flag and the committed configuration bits. It answers with a one-hot chip select, the address translated into the chosen device's own space, a write qualifier, and an open-bus flag. Six targets exist: a 1 MB boot ROM, a 512 KB pseudo-static RAM, an extra-memory region with no chip fitted, a 1 MB external flash pack, a 32 KB battery SRAM and the configuration register port.

Four of the regions overlap. They are resolved by a fixed order: boot ROM first, then pseudo-static RAM, then extra memory, then flash. The register port and the SRAM sit in an area that no other region reaches. Banks 00h–7Dh form the slow half and banks 80h–FFh the fast half. Most regions have a separate enable for each half. A mode bit chooses low-style packing (bank above a 15-bit offset, address bit 15 dropped) or high-style packing (bank above the full 16-bit offset).

Requests enter on a valid/ready port and results leave on a valid/ready port through one register stage. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds steady.

Top module: `cartmap_decoder`

## Requirements
- R1: At most one bit of `out_sel` is set. The bit order is 0 boot ROM, 1 pseudo-static RAM, 2 extra memory, 3 flash, 4 SRAM, 5 register port. When no bit is set, or when extra memory is selected, `out_open_bus` is 1; otherwise it is 0. An unselected result has `out_addr` 0.
- R2: Banks 00h–0Fh at offsets 5000h–5FFFh select the register port with address = bank. Banks 10h–17h at the same offsets select the SRAM with address = (bank−10h)×1000h + (offset−5000h). These areas are decoded regardless of the configuration bits.
- R3: With cfg bit 7, banks 00h–3Fh at offsets 8000h–FFFFh select the boot ROM. With cfg bit 8, banks 80h–BFh at the same offsets do so. The address is (bank mod 20h)×8000h + (offset mod 8000h). This region beats every other one.
- R4: With cfg bit 2 = 0 (low style), the RAM window is picked by n = cfg bits 6:5. It starts at bank n×20h and spans 10h banks: upper 32K only when n < 2, full banks otherwise. The fast half is the same banks plus 80h. Cfg bit 3 enables the slow half and bit 4 the fast half. The address is (bank mod 10h)×8000h + (offset mod 8000h).
- R5: In low style, the lower 32K of banks 70h–7Dh and F0h–FFh also select the RAM, with the R4 address rule. This ignores n but obeys bits 3 and 4.
- R6: With cfg bit 2 = 1 (high style), the RAM takes banks n×10h to n×10h+7 at the upper 32K, and banks 40h+n×10h to 40h+n×10h+7 in full. The fast half is the same banks plus 80h and is gated by bits 3 and 4. The address is (bank mod 8)×10000h + offset.
- R7: In high style, offsets 6000h–7FFFh of banks 20h–3Fh (bit 3) and A0h–BFh (bit 4) select the RAM at (bank mod 8)×10000h + offset, whatever n is.
- R8: Extra memory is gated by cfg bit 9 (slow half) and bit 10 (fast half), and its location is set by bit 11. In low style, location 0 gives banks 00h–1Fh at the upper 32K and location 1 gives banks 40h–5Fh in full; the address is (bank mod 20h)×8000h + (offset mod 8000h). In high style, location 0 gives 00h–0Fh at the upper 32K plus 40h–4Fh in full, and location 1 gives 20h–2Fh at the upper 32K plus 60h–6Fh in full; the address is (bank mod 10h)×10000h + offset. The fast half is the same banks plus 80h.
- R9: The flash is always enabled. It covers banks 00h–3Fh and 80h–BFh at offsets 8000h–FFFFh, and banks 40h–7Dh and C0h–FFh in full. Its address is (bank mod 20h)×8000h + (offset mod 8000h) in low style, or (bank mod 10h)×10000h + offset in high style.
- R10: `out_wr_ok` is 1 only for a write that selects the RAM, extra memory, the SRAM, the register port, or the flash with cfg bit 12 = 1. It is never 1 for the boot ROM.
- R11: An accepted request (`in_valid` and `in_ready` at an edge) shows its result with `out_valid` from that edge on. The result is held unchanged until `out_ready` is sampled high. `in_ready` = not `out_valid` or `out_ready`.
- R12: While `rst` is high, `out_valid` is cleared at each edge and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted at this edge |
| in_bank | input | 8 | Bus address bank |
| in_off | input | 16 | Bus address offset |
| in_wr | input | 1 | Request is a write |
| cfg | input | 11 | Committed control bits 12..2 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken at this edge |
| out_sel | output | 6 | One-hot chip select |
| out_addr | output | 24 | Device-local address |
| out_wr_ok | output | 1 | Write reaches the selected device |
| out_open_bus | output | 1 | No device drives read data |

## Verification
Every decoded field (`out_sel`, `out_addr`, `out_wr_ok`, `out_open_bus`) is due at the first clock edge after the edge that accepts the request, and stays until the edge where `out_ready` is high. The bench drives inputs just after the falling edge. One nanosecond later it compares the registered outputs against a queue of expected results. It pops an entry only when the handshake will complete at the next edge. Stalled cycles are therefore compared again against the same entry, and a queue occupancy that disagrees with `out_valid` is reported against R11.

// File: rtl/cartmap_pkg.sv
package cartmap_pkg;
  localparam int BANK_W  = 8;
  localparam int OFF_W   = 16;
  localparam int ADDR_W  = 24;
  localparam int NUM_DEV = 6;

  // select bit positions, also the priority order for the overlapping four
  localparam int DEV_BOOT  = 0;
  localparam int DEV_PSRAM = 1;
  localparam int DEV_EXT   = 2;
  localparam int DEV_FLASH = 3;
  localparam int DEV_SRAM  = 4;
  localparam int DEV_PORT  = 5;

  // control bit positions as written by the configuration register
  localparam int CB_HIMODE    = 2;
  localparam int CB_PS_SLOW   = 3;
  localparam int CB_PS_FAST   = 4;
  localparam int CB_PS_LOC_LO = 5;
  localparam int CB_PS_LOC_HI = 6;
  localparam int CB_BOOT_SLOW = 7;
  localparam int CB_BOOT_FAST = 8;
  localparam int CB_EXT_SLOW  = 9;
  localparam int CB_EXT_FAST  = 10;
  localparam int CB_EXT_LOC   = 11;
  localparam int CB_FLASH_WE  = 12;
  localparam int CFG_LO       = 2;
  localparam int CFG_HI       = 12;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] addr;
  } hit_t;

  // bank packed above the low 15 offset bits
  function automatic logic [ADDR_W-1:0] lo_style(input logic [BANK_W-1:0] b,
                                                 input logic [OFF_W-2:0] o);
    return ADDR_W'({b, o});
  endfunction

  // bank packed above the full offset
  function automatic logic [ADDR_W-1:0] hi_style(input logic [BANK_W-1:0] b,
                                                 input logic [OFF_W-1:0] o);
    return {b, o};
  endfunction

  function automatic logic [ADDR_W-1:0] width_mask(input int aw);
    return ADDR_W'((64'(1) << aw) - 64'(1));
  endfunction
endpackage

// File: rtl/cartmap_fixed_dec.sv
module cartmap_fixed_dec
  import cartmap_pkg::*;
#(
  parameter int SRAM_AW = 15
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  output hit_t              port_res,
  output hit_t              sram_res
);
  localparam logic [ADDR_W-1:0] SRAM_MASK = width_mask(SRAM_AW);

  logic io_window;
  assign io_window = (off[15:12] == 4'h5);

  always_comb begin
    port_res.hit  = io_window && (bank[7:4] == 4'h0);
    port_res.addr = ADDR_W'(bank[3:0]);
    sram_res.hit  = io_window && (bank[7:3] == 5'b00010);
    sram_res.addr = ADDR_W'({bank[2:0], off[11:0]}) & SRAM_MASK;
  end
endmodule

// File: rtl/cartmap_rom_dec.sv
module cartmap_rom_dec
  import cartmap_pkg::*;
#(
  parameter int BOOT_AW  = 20,
  parameter int FLASH_AW = 20
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  input  logic              hi_mode,
  input  logic              boot_slow_en,
  input  logic              boot_fast_en,
  output hit_t              boot_res,
  output hit_t              flash_res
);
  localparam logic [ADDR_W-1:0] BOOT_MASK  = width_mask(BOOT_AW);
  localparam logic [ADDR_W-1:0] FLASH_MASK = width_mask(FLASH_AW);

  logic slow_half, fast_half, upper32;
  assign slow_half = (bank <= 8'h7D);
  assign fast_half = bank[7];
  assign upper32   = off[15];

  always_comb begin
    // boot ROM lives in the lower quarter of each half, low-style only
    boot_res.hit  = upper32 && (bank[6] == 1'b0) &&
                    ((!bank[7] && boot_slow_en) || (bank[7] && boot_fast_en));
    boot_res.addr = lo_style(bank, off[14:0]) & BOOT_MASK;

    // flash pack is always present as the lowest-priority background
    flash_res.hit  = (slow_half || fast_half) && (bank[6] || upper32);
    flash_res.addr = (hi_mode ? hi_style(bank, off) : lo_style(bank, off[14:0]))
                     & FLASH_MASK;
  end
endmodule

// File: rtl/cartmap_psram_dec.sv
module cartmap_psram_dec
  import cartmap_pkg::*;
#(
  parameter int PSRAM_AW = 19,
  parameter int NUM_LOC  = 4
) (
  input  logic [BANK_W-1:0]          bank,
  input  logic [OFF_W-1:0]           off,
  input  logic                       hi_mode,
  input  logic                       slow_en,
  input  logic                       fast_en,
  input  logic [$clog2(NUM_LOC)-1:0] loc,
  output hit_t                       res
);
  localparam logic [ADDR_W-1:0] MASK = width_mask(PSRAM_AW);
  localparam int LOC_W = $clog2(NUM_LOC);

  logic [NUM_LOC-1:0] lo_win;
  logic [NUM_LOC-1:0] hi_win;

  for (genvar n = 0; n < NUM_LOC; n++) begin : g_win
    // low style: 16-bank window at n*20h; first two windows upper 32K only
    localparam logic [2:0] LO_GRP   = 3'(2 * n);
    localparam bit         LO_UPPER = (n < 2);
    // high style: 8-bank group at n*10h (upper) and 40h+n*10h (full)
    localparam logic [2:0] HI_UPPER = 3'(n);
    localparam logic [2:0] HI_FULL  = 3'(4 + n);

    assign lo_win[n] = (bank[6:4] == LO_GRP) && (!LO_UPPER || off[15]);
    assign hi_win[n] = !bank[3] &&
                       (((bank[6:4] == HI_UPPER) && off[15]) ||
                        (bank[6:4] == HI_FULL));
  end

  logic half_en, fixed_lo, snippet_hi, win_lo, win_hi;

  assign half_en    = bank[7] ? fast_en : ((bank <= 8'h7D) && slow_en);
  // lower 32K of banks 70h-7Dh / F0h-FFh, independent of location
  assign fixed_lo   = !off[15] && (bank[6:4] == 3'b111);
  // 8K slices at 6000h-7FFFh of banks 20h-3Fh / A0h-BFh
  assign snippet_hi = (off[15:13] == 3'b011) && (bank[6:5] == 2'b01);
  assign win_lo     = lo_win[loc];
  assign win_hi     = hi_win[loc];

  always_comb begin
    res.hit  = half_en && (hi_mode ? (win_hi || snippet_hi) : (win_lo || fixed_lo));
    res.addr = (hi_mode ? hi_style(bank, off) : lo_style(bank, off[14:0])) & MASK;
  end

  logic [LOC_W-1:0] unused_loc_w;
  assign unused_loc_w = '0;
endmodule

// File: rtl/cartmap_ext_dec.sv
module cartmap_ext_dec
  import cartmap_pkg::*;
#(
  parameter int EXT_AW = 20
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  input  logic              hi_mode,
  input  logic              slow_en,
  input  logic              fast_en,
  input  logic              loc,
  output hit_t              res
);
  localparam logic [ADDR_W-1:0] MASK = width_mask(EXT_AW);

  logic half_en, lo_hit, hi_hit;

  assign half_en = bank[7] ? fast_en : ((bank <= 8'h7D) && slow_en);

  // low style: 32-bank window, upper 32K at 00h or full at 40h
  assign lo_hit = loc ? (bank[6:5] == 2'b10)
                      : ((bank[6:5] == 2'b00) && off[15]);
  // high style: 16-bank upper window plus 16-bank full window
  assign hi_hit = loc ? (((bank[6:4] == 3'b010) && off[15]) || (bank[6:4] == 3'b110))
                      : (((bank[6:4] == 3'b000) && off[15]) || (bank[6:4] == 3'b100));

  always_comb begin
    res.hit  = half_en && (hi_mode ? hi_hit : lo_hit);
    res.addr = (hi_mode ? hi_style(bank, off) : lo_style(bank, off[14:0])) & MASK;
  end
endmodule

// File: rtl/cartmap_decoder.sv
module cartmap_decoder
  import cartmap_pkg::*;
#(
  parameter int BOOT_AW  = 20,
  parameter int PSRAM_AW = 19,
  parameter int EXT_AW   = 20,
  parameter int FLASH_AW = 20,
  parameter int SRAM_AW  = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BANK_W-1:0]   in_bank,
  input  logic [OFF_W-1:0]    in_off,
  input  logic                in_wr,
  input  logic [CFG_HI:CFG_LO] cfg,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [NUM_DEV-1:0]  out_sel,
  output logic [ADDR_W-1:0]   out_addr,
  output logic                out_wr_ok,
  output logic                out_open_bus
);
  hit_t port_r, sram_r, boot_r, flash_r, psram_r, ext_r;

  cartmap_fixed_dec #(.SRAM_AW(SRAM_AW)) u_fixed (
    .bank     (in_bank),
    .off      (in_off),
    .port_res (port_r),
    .sram_res (sram_r)
  );

  cartmap_rom_dec #(.BOOT_AW(BOOT_AW), .FLASH_AW(FLASH_AW)) u_rom (
    .bank         (in_bank),
    .off          (in_off),
    .hi_mode      (cfg[CB_HIMODE]),
    .boot_slow_en (cfg[CB_BOOT_SLOW]),
    .boot_fast_en (cfg[CB_BOOT_FAST]),
    .boot_res     (boot_r),
    .flash_res    (flash_r)
  );

  cartmap_psram_dec #(.PSRAM_AW(PSRAM_AW), .NUM_LOC(4)) u_psram (
    .bank    (in_bank),
    .off     (in_off),
    .hi_mode (cfg[CB_HIMODE]),
    .slow_en (cfg[CB_PS_SLOW]),
    .fast_en (cfg[CB_PS_FAST]),
    .loc     (cfg[CB_PS_LOC_HI:CB_PS_LOC_LO]),
    .res     (psram_r)
  );

  cartmap_ext_dec #(.EXT_AW(EXT_AW)) u_ext (
    .bank    (in_bank),
    .off     (in_off),
    .hi_mode (cfg[CB_HIMODE]),
    .slow_en (cfg[CB_EXT_SLOW]),
    .fast_en (cfg[CB_EXT_FAST]),
    .loc     (cfg[CB_EXT_LOC]),
    .res     (ext_r)
  );

  // fixed-priority resolution; register port and SRAM never overlap the rest
  logic [NUM_DEV-1:0] sel_d;
  logic [ADDR_W-1:0]  addr_d;
  logic               wr_ok_d, open_d;

  always_comb begin
    sel_d  = '0;
    addr_d = '0;
    if (port_r.hit) begin
      sel_d[DEV_PORT] = 1'b1;  addr_d = port_r.addr;
    end else if (sram_r.hit) begin
      sel_d[DEV_SRAM] = 1'b1;  addr_d = sram_r.addr;
    end else if (boot_r.hit) begin
      sel_d[DEV_BOOT] = 1'b1;  addr_d = boot_r.addr;
    end else if (psram_r.hit) begin
      sel_d[DEV_PSRAM] = 1'b1; addr_d = psram_r.addr;
    end else if (ext_r.hit) begin
      sel_d[DEV_EXT] = 1'b1;   addr_d = ext_r.addr;
    end else if (flash_r.hit) begin
      sel_d[DEV_FLASH] = 1'b1; addr_d = flash_r.addr;
    end
    wr_ok_d = in_wr && (sel_d[DEV_PSRAM] || sel_d[DEV_EXT] || sel_d[DEV_SRAM] ||
                        sel_d[DEV_PORT] || (sel_d[DEV_FLASH] && cfg[CB_FLASH_WE]));
    open_d  = (sel_d == '0) || sel_d[DEV_EXT];
  end

  // single output register stage with valid/ready
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sel      <= '0;
      out_addr     <= '0;
      out_wr_ok    <= 1'b0;
      out_open_bus <= 1'b0;
    end else if (take) begin
      out_sel      <= sel_d;
      out_addr     <= addr_d;
      out_wr_ok    <= wr_ok_d;
      out_open_bus <= open_d;
    end
  end
endmodule

// File: rtl/cartmap_decoder_chk.sv
module cartmap_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_bank,
  input logic [3:0]  off_top,
  input logic        boot_slow_en,
  input logic        out_valid,
  input logic        out_ready,
  input logic [5:0]  out_sel,
  input logic [23:0] out_addr,
  input logic        out_wr_ok,
  input logic        out_open_bus
);
  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(out_sel));

  a_r1_open_when_none: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sel == 6'b0) |-> out_open_bus);

  a_r2_sram_fixed: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_bank[7:3] == 5'b00010 && off_top == 4'h5)
      |=> (out_valid && out_sel == 6'b010000));

  a_r3_boot_wins: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && boot_slow_en && in_bank <= 8'h3F && off_top[3])
      |=> (out_valid && out_sel == 6'b000001));

  a_r10_rom_no_write: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sel[0]) |-> !out_wr_ok);

  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready)
      |=> (out_valid && $stable(out_sel) && $stable(out_addr) &&
           $stable(out_wr_ok) && $stable(out_open_bus)));

  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind cartmap_decoder cartmap_decoder_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_bank      (in_bank),
  .off_top      (in_off[15:12]),
  .boot_slow_en (cfg[7]),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_sel      (out_sel),
  .out_addr     (out_addr),
  .out_wr_ok    (out_wr_ok),
  .out_open_bus (out_open_bus)
);

// File: tb/tb_cartmap_decoder.sv
module tb_cartmap_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_wr, out_valid, out_ready;
  logic [7:0]  in_bank;
  logic [15:0] in_off;
  logic [12:2] cfg;
  logic [5:0]  out_sel;
  logic [23:0] out_addr;
  logic        out_wr_ok, out_open_bus;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [5:0] q_sel[$];
  int         q_addr[$];
  bit         q_wok[$];
  bit         q_ob[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  cartmap_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bank(in_bank), .in_off(in_off), .in_wr(in_wr), .cfg(cfg),
    .out_valid(out_valid), .out_ready(out_ready), .out_sel(out_sel),
    .out_addr(out_addr), .out_wr_ok(out_wr_ok), .out_open_bus(out_open_bus)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference written from the requirement text
  task automatic model(input int b, input int o, input bit w, input int c,
                       output logic [5:0] s, output int a, output bit wok,
                       output bit ob, output string tag);
    bit hi   = c[2];
    bit slow = (b <= 'h7D);
    bit fast = (b >= 'h80);
    int bb   = b % 128;
    int ploc = (c >> 5) & 3;
    bit pen  = slow ? c[3] : (fast ? c[4] : 1'b0);
    bit een  = slow ? c[9] : (fast ? c[10] : 1'b0);
    bit up   = (o >= 'h8000);
    s = 6'b0; a = 0; tag = "R1";
    if (b <= 'h0F && o >= 'h5000 && o <= 'h5FFF) begin
      s = 6'b100000; a = b; tag = "R2";
    end else if (b >= 'h10 && b <= 'h17 && o >= 'h5000 && o <= 'h5FFF) begin
      s = 6'b010000; a = (b - 'h10) * 'h1000 + (o - 'h5000); tag = "R2";
    end else if (up && ((b <= 'h3F && c[7]) || (b >= 'h80 && b <= 'hBF && c[8]))) begin
      s = 6'b000001; a = (b % 32) * 'h8000 + (o % 'h8000); tag = "R3";
    end else if (pen && !hi && ((bb >= ploc * 32 && bb < ploc * 32 + 16 && (ploc >= 2 || up)))) begin
      s = 6'b000010; a = (bb % 16) * 'h8000 + (o % 'h8000); tag = "R4";
    end else if (pen && !hi && bb >= 'h70 && !up) begin
      s = 6'b000010; a = (bb % 16) * 'h8000 + (o % 'h8000); tag = "R5";
    end else if (pen && hi && ((bb >= ploc * 16 && bb < ploc * 16 + 8 && up) ||
                               (bb >= 64 + ploc * 16 && bb < 64 + ploc * 16 + 8))) begin
      s = 6'b000010; a = (bb % 8) * 'h10000 + o; tag = "R6";
    end else if (pen && hi && bb >= 32 && bb < 64 && o >= 'h6000 && o < 'h8000) begin
      s = 6'b000010; a = (bb % 8) * 'h10000 + o; tag = "R7";
    end else if (een && !hi && ((!c[11] && bb < 32 && up) || (c[11] && bb >= 64 && bb < 96))) begin
      s = 6'b000100; a = (bb % 32) * 'h8000 + (o % 'h8000); tag = "R8";
    end else if (een && hi && ((!c[11] && ((bb < 16 && up) || (bb >= 64 && bb < 80))) ||
                               (c[11] && ((bb >= 32 && bb < 48 && up) || (bb >= 96 && bb < 112))))) begin
      s = 6'b000100; a = (bb % 16) * 'h10000 + o; tag = "R8";
    end else if ((slow || fast) && (bb >= 64 || up)) begin
      s = 6'b001000; tag = "R9";
      a = hi ? (b % 16) * 'h10000 + o : (b % 32) * 'h8000 + (o % 'h8000);
    end
    wok = w && (s[1] || s[2] || s[4] || s[5] || (s[3] && c[12]));
    ob  = (s == 6'b0) || s[2];
  endtask

  task automatic cycle(input bit v, input int b, input int o, input bit w,
                       input int c, input bit rdy);
    logic [5:0] es; int ea; bit ew, eo; string et;
    @(negedge clk);
    in_valid = v; in_bank = 8'(b); in_off = 16'(o); in_wr = w;
    cfg = c[12:2]; out_ready = rdy;
    #1;
    check(out_valid == (q_sel.size() != 0), "R11", "out_valid", out_valid, q_sel.size());
    if (out_valid && q_sel.size() != 0) begin
      check(out_sel == q_sel[0], q_tag[0], "sel", out_sel, q_sel[0]);
      check(out_addr == 24'(q_addr[0]), q_tag[0], "addr", out_addr, q_addr[0]);
      check(out_wr_ok == q_wok[0], "R10", "wr_ok", out_wr_ok, q_wok[0]);
      check(out_open_bus == q_ob[0], q_sel[0][2] ? "R8" : "R1", "open_bus",
            out_open_bus, q_ob[0]);
      check(in_ready == out_ready, "R11", "in_ready", in_ready, out_ready);
      if (out_ready) begin
        void'(q_sel.pop_front()); void'(q_addr.pop_front());
        void'(q_wok.pop_front()); void'(q_ob.pop_front()); void'(q_tag.pop_front());
      end
    end
    if (in_valid && in_ready) begin
      model(b, o, w, c, es, ea, ew, eo, et);
      q_sel.push_back(es); q_addr.push_back(ea); q_wok.push_back(ew);
      q_ob.push_back(eo); q_tag.push_back(et);
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 0; in_bank = 0; in_off = 0; in_wr = 0; cfg = '0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R12", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R12", "in_ready in reset", in_ready, 1);
    @(negedge clk); rst = 1'b0;

    // directed: each region, each mode
    cycle(1, 'h00, 'h8000, 0, 'h198, 1);          // R3 boot over RAM window
    cycle(1, 'hB5, 'hFFFF, 1, 'h198, 1);          // R3 fast half, R10 ROM write
    cycle(1, 'h05, 'h9234, 0, 'h018, 1);          // R4 low window 0
    cycle(1, 'h43, 'h1234, 1, 'h058, 1);          // R4 low window 2, full bank
    cycle(1, 'h05, 'h1234, 0, 'h018, 1);          // R4 lower half not mapped -> R1
    cycle(1, 'h7C, 'h0123, 0, 'h078, 1);          // R5 fixed slow area
    cycle(1, 'hF5, 'h7FFF, 0, 'h010, 1);          // R5 fixed fast area
    cycle(1, 'h7E, 'h1234, 0, 'hFFFF, 1);         // R1 open bus, banks 7Eh
    cycle(1, 'h13, 'h9000, 0, 'h03C, 1);          // R6 high upper group
    cycle(1, 'hD3, 'h0010, 0, 'h01C | 'h20, 1);   // R6 high full group
    cycle(1, 'h2B, 'h6ABC, 1, 'h07C, 1);          // R7 snippet
    cycle(1, 'h1F, 'h8000, 1, 'h200, 1);          // R8 low loc 0
    cycle(1, 'hE4, 'h4000, 0, 'hC04, 1);          // R8 high loc 1 fast
    cycle(1, 'h45, 'h1234, 1, 'h1000, 1);         // R9 flash writable
    cycle(1, 'h45, 'h1234, 1, 'h0004, 1);         // R9 high style, R10 write blocked
    cycle(1, 'h12, 'h5ABC, 1, 'h0000, 1);         // R2 SRAM
    cycle(1, 'h0A, 'h5001, 0, 'hFFFF, 1);         // R2 register port
    cycle(1, 'h20, 'h5000, 0, 'h0000, 1);         // R1 open bus
    // back-pressure: R11 hold
    cycle(1, 'h41, 'h0000, 0, 'h0000, 0);
    cycle(1, 'h12, 'h5000, 0, 'h0000, 0);
    cycle(0, 0, 0, 0, 0, 0);
    cycle(1, 'h12, 'h5000, 0, 'h0000, 1);
    cycle(0, 0, 0, 0, 0, 1);

    // random traffic with random control words and random stalls
    for (int i = 0; i < 6000; i++) begin
      cycle($urandom_range(0, 3) != 0, $urandom_range(0, 255), $urandom_range(0, 65535),
            $urandom_range(0, 1), $urandom_range(0, 'h1FFF), $urandom_range(0, 3) != 0);
    end
    repeat (4) cycle(0, 0, 0, 0, 0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule